// File: doc/BRIEF.md
# Receive Descriptor DMA Control State Machine

This block sequences the receive side of a descriptor-driven DMA engine. Software programs the base address of a descriptor ring and issues a start command. The engine then fetches one descriptor's ownership word over a simple request/acknowledge memory port. It runs while descriptors belong to the DMA, advances one descriptor each time the data path reports that the current descriptor is consumed, and parks in a Suspended state when the descriptor it needs still belongs to the host.

Software wakes a suspended engine by writing any value to the poll register. The engine then fetches the same descriptor again; it does not go back to the start of the ring. A wake-up that still finds a host-owned descriptor sends the engine back to Suspended quietly, without raising the unavailable flag a second time. The unavailable flag is a write-one-to-clear status bit. A stop command returns the engine to Stopped, but a fetch already in flight is allowed to finish first.

Top module: `rxdesc_ctrl`

## Requirements
- R1: After reset, `rx_state` is 0 and `cur_ptr`, `mem_req`, `unavail` and the readback of all three registers are 0. The `rx_state` codes are: 0 Stopped, 1 Fetching, 2 Active, 3 Suspended.
- R2: A write to the base register (`reg_sel`=1) is stored only when `rx_state` is Stopped. At any other time the write is ignored and the readback keeps its old value.
- R3: The two low bits of the base register are forced to zero. They read back as zero whatever value is written.
- R4: A start command given in Stopped copies the base register into `cur_ptr` and enters Fetching. In Fetching, `mem_req` is high and `mem_addr` equals `cur_ptr`.
- R5: The fetched word's bit 31 gives ownership. When it is 1 the engine goes to Active. When it is 0 after a start or an advance, the engine goes to Suspended and sets `unavail`, which is status bit 7 (`reg_sel`=2).
- R6: The engine enters Suspended only when a fetch completes with bit 31 equal to 0.
- R7: A write of any value to the poll register (`reg_sel`=0) is stored for readback and raises a one-cycle wake event. In Suspended, this event makes the engine fetch the descriptor at the unchanged `cur_ptr`.
- R8: If a fetch started by a poll finds a host-owned descriptor, the engine returns to Suspended and leaves `unavail` unset.
- R9: If a fetch started by a poll finds a DMA-owned descriptor, the engine returns to Active.
- R10: A poll event that arrives in Stopped or Active has no effect on the state and issues no fetch.
- R11: `desc_done` in Active adds 16 to `cur_ptr` and starts a fetch at the new address.
- R12: `stop_cmd` in Active or Suspended gives Stopped one cycle later. During Fetching, the engine waits for the acknowledge and then goes to Stopped, whatever the descriptor owner.
- R13: Writing a 1 to status bit 7 clears `unavail`. Writing a 0 to that bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 poll, 1 base, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the selected register |
| start_cmd | input | 1 | Start reception |
| stop_cmd | input | 1 | Stop reception |
| desc_done | input | 1 | Current descriptor consumed by the data path |
| mem_req | output | 1 | Descriptor fetch request |
| mem_addr | output | 32 | Fetch address |
| mem_ack | input | 1 | Fetch response valid |
| mem_rdata | input | 32 | Fetched descriptor ownership word |
| rx_state | output | 2 | Engine state code |
| cur_ptr | output | 32 | Current descriptor address |
| unavail | output | 1 | Descriptor-unavailable flag |

## Verification
- A start pulse or `desc_done` shows up as Fetching after one clock edge.
- The bench's memory model acknowledges one edge after the request. The resulting Active or Suspended state, together with `unavail`, appears one edge after that, which is two edges after the fetch began.
- A poll write becomes a registered wake pulse at the edge that takes the write. The fetch therefore starts one edge later, and the outcome comes two edges after that.
- Each task steps exactly these edge counts and samples at the falling edge in between. Ignored stimuli (a base write outside Stopped, a poll in Stopped or Active) are checked after at least three edges, through the readback and through the state and request outputs.

// File: rtl/rxd_pkg.sv
// Shared types for the receive descriptor control block.
// Assumes a two-bit register select and a 32-bit status word.
package rxd_pkg;
    typedef enum logic [1:0] {
        ST_STOP   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_SUSP   = 2'd3
    } rx_state_t;

    localparam logic [1:0] SEL_POLL = 2'd0;
    localparam logic [1:0] SEL_BASE = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;
    localparam int         FLAG_BIT = 7;
endpackage

// File: rtl/rxd_regs.sv
// Register file: poll register with wake pulse, base address register with
// alignment masking and stop-only write, status word with W1C unavailable flag.
// Assumes DATA_W >= ADDR_W and that reg_wr is a single-cycle strobe.
module rxd_regs
    import rxd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              is_stopped,
    input  logic              set_unavail,
    output logic              poll_pulse,
    output logic [ADDR_W-1:0] base_q,
    output logic              unavail
);
    logic [DATA_W-1:0] poll_q;
    logic [ADDR_W-1:0] base_in;

    // Alignment variant chosen by parameter
    generate
        if (ALIGN_BITS > 0) begin : g_mask
            localparam logic [ADDR_W-1:0] KEEP = {ADDR_W{1'b1}} << ALIGN_BITS;
            assign base_in = reg_wdata[ADDR_W-1:0] & KEEP;
        end else begin : g_nomask
            assign base_in = reg_wdata[ADDR_W-1:0];
        end
    endgenerate

    // Poll register value and wake pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_q     <= '0;
            poll_pulse <= 1'b0;
        end else begin
            poll_pulse <= reg_wr && (reg_sel == SEL_POLL);
            if (reg_wr && (reg_sel == SEL_POLL))
                poll_q <= reg_wdata;
        end
    end

    // Base register, writable only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (reg_wr && (reg_sel == SEL_BASE) && is_stopped)
            base_q <= base_in;
    end

    // Unavailable flag: set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            unavail <= 1'b0;
        else if (set_unavail)
            unavail <= 1'b1;
        else if (reg_wr && (reg_sel == SEL_STAT) && reg_wdata[FLAG_BIT])
            unavail <= 1'b0;
    end

    // Readback mux
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_POLL: reg_rdata = poll_q;
            SEL_BASE: reg_rdata = DATA_W'(base_q);
            SEL_STAT: reg_rdata[FLAG_BIT] = unavail;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rxd_fsm.sv
// Descriptor walk state machine: start, advance, suspend, poll wake-up, stop.
// Assumes mem_ack arrives while mem_req is held and pulses once per fetch.
module rxd_fsm
    import rxd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int DESC_BYTES = 16,
    parameter int OWN_BIT    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic              desc_done,
    input  logic              poll_pulse,
    input  logic [ADDR_W-1:0] base_q,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output rx_state_t         state,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              set_unavail
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_BYTES);

    rx_state_t         nxt;
    logic [ADDR_W-1:0] ptr_n;
    logic              from_poll, from_poll_n;
    logic              stop_pend, stop_pend_n;

    // Next-state and pointer decision
    always_comb begin
        nxt         = state;
        ptr_n       = cur_ptr;
        from_poll_n = from_poll;
        stop_pend_n = stop_pend;
        set_unavail = 1'b0;
        case (state)
            ST_STOP: begin
                if (start_cmd && !stop_cmd) begin
                    nxt         = ST_FETCH;
                    ptr_n       = base_q;
                    from_poll_n = 1'b0;
                    stop_pend_n = 1'b0;
                end
            end
            ST_FETCH: begin
                if (stop_cmd)
                    stop_pend_n = 1'b1;
                if (mem_ack) begin
                    stop_pend_n = 1'b0;
                    if (stop_cmd || stop_pend)
                        nxt = ST_STOP;
                    else if (mem_rdata[OWN_BIT])
                        nxt = ST_ACTIVE;
                    else begin
                        nxt         = ST_SUSP;
                        set_unavail = !from_poll;
                    end
                end
            end
            ST_ACTIVE: begin
                if (stop_cmd)
                    nxt = ST_STOP;
                else if (desc_done) begin
                    nxt         = ST_FETCH;
                    ptr_n       = cur_ptr + STRIDE;
                    from_poll_n = 1'b0;
                end
            end
            ST_SUSP: begin
                if (stop_cmd)
                    nxt = ST_STOP;
                else if (poll_pulse) begin
                    nxt         = ST_FETCH;
                    from_poll_n = 1'b1;
                end
            end
            default: nxt = ST_STOP;
        endcase
    end

    // State and pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_STOP;
            cur_ptr   <= '0;
            from_poll <= 1'b0;
            stop_pend <= 1'b0;
        end else begin
            state     <= nxt;
            cur_ptr   <= ptr_n;
            from_poll <= from_poll_n;
            stop_pend <= stop_pend_n;
        end
    end

    // Memory request follows the fetch state
    assign mem_req  = (state == ST_FETCH);
    assign mem_addr = cur_ptr;
endmodule

// File: rtl/rxdesc_ctrl.sv
// Top of the receive descriptor control block: joins the register file and
// the walk state machine. Assumes a single clock and synchronous reset.
module rxdesc_ctrl
    import rxd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int ALIGN_BITS = 2,
    parameter int DESC_BYTES = 16,
    parameter int OWN_BIT    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic              desc_done,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [1:0]        rx_state,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              unavail
);
    rx_state_t         state;
    logic              poll_pulse;
    logic              set_unavail;
    logic [ADDR_W-1:0] base_q;

    rxd_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .is_stopped(state == ST_STOP), .set_unavail(set_unavail),
        .poll_pulse(poll_pulse), .base_q(base_q), .unavail(unavail)
    );

    rxd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DESC_BYTES(DESC_BYTES), .OWN_BIT(OWN_BIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .desc_done(desc_done), .poll_pulse(poll_pulse), .base_q(base_q),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .state(state),
        .cur_ptr(cur_ptr), .mem_req(mem_req), .mem_addr(mem_addr),
        .set_unavail(set_unavail)
    );

    assign rx_state = state;
endmodule

// File: rtl/rxd_checker.sv
// Assertion checker bound to rxdesc_ctrl; observes ports and the base register.
module rxd_checker
    import rxd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int ALIGN_BITS = 2,
    parameter int OWN_BIT    = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        rx_state,
    input logic [ADDR_W-1:0] cur_ptr,
    input logic [ADDR_W-1:0] base_q,
    input logic              mem_ack,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              stop_cmd,
    input logic              unavail
);
    // R6: Suspended is entered only after a host-owned fetch result
    a_r6_susp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == ST_SUSP && $past(rx_state) != ST_SUSP)
        |-> ($past(rx_state) == ST_FETCH && $past(mem_ack) && !$past(mem_rdata[OWN_BIT])));

    // R7: a poll wake-up refetches at the unchanged pointer
    a_r7_poll_same_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == ST_FETCH && $past(rx_state) == ST_SUSP) |-> $stable(cur_ptr));

    // R2: base register frozen outside Stopped
    a_r2_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state != ST_STOP) |=> $stable(base_q));

    // R5: flag rises only on a fetch that found a host-owned descriptor
    a_r5_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unavail) |-> ($past(rx_state) == ST_FETCH && $past(mem_ack)
                            && !$past(mem_rdata[OWN_BIT])));

    // R12: stop from Active or Suspended takes one cycle
    a_r12_stop_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && (rx_state == ST_ACTIVE || rx_state == ST_SUSP)) |=> rx_state == ST_STOP);

    // R3: pointer stays aligned
    a_r3_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ptr[ALIGN_BITS-1:0] == '0);
endmodule

bind rxdesc_ctrl rxd_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS), .OWN_BIT(OWN_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_state(rx_state), .cur_ptr(cur_ptr),
    .base_q(base_q), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .stop_cmd(stop_cmd), .unavail(unavail)
);

// File: tb/rxdesc_ctrl_bench.sv
// Directed bench for rxdesc_ctrl: one task per scenario, 50 MHz clock.
module rxdesc_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        start_cmd = 1'b0, stop_cmd = 1'b0, desc_done = 1'b0;
    logic        mem_req, mem_ack;
    logic [31:0] mem_addr, mem_rdata, cur_ptr;
    logic [1:0]  rx_state;
    logic        unavail;

    logic        own [8];
    logic        hold_ack = 1'b0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    localparam logic [1:0] S_STOP = 2'd0, S_FETCH = 2'd1, S_ACT = 2'd2, S_SUSP = 2'd3;

    always #10 clk = ~clk;

    rxdesc_ctrl u_rxdesc_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_cmd(start_cmd),
        .stop_cmd(stop_cmd), .desc_done(desc_done), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rx_state(rx_state), .cur_ptr(cur_ptr), .unavail(unavail)
    );

    // Memory model: acknowledge one edge after a request, owner bit from own[]
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !hold_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= {own[mem_addr[6:4]], 31'h0000_1234};
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 state", 32'(rx_state), 32'(S_STOP));
        chk("R1 ptr", cur_ptr, 0);
        chk("R1 req", 32'(mem_req), 0);
        chk("R1 unavail", 32'(unavail), 0);
        rd(2'd0, v); chk("R1 poll rd", v, 0);
        rd(2'd1, v); chk("R1 base rd", v, 0);
        rd(2'd2, v); chk("R1 stat rd", v, 0);
    endtask

    task automatic t_base_align();
        logic [31:0] v;
        wr(2'd1, 32'h0000_1003);
        rd(2'd1, v); chk("R3 low bits zero", v, 32'h0000_1000);
    endtask

    task automatic t_start_owned();
        own[0] = 1'b1;
        pulse(start_cmd);
        chk("R4 fetching", 32'(rx_state), 32'(S_FETCH));
        chk("R4 req", 32'(mem_req), 1);
        chk("R4 addr", mem_addr, 32'h0000_1000);
        step(2);
        chk("R5 owned active", 32'(rx_state), 32'(S_ACT));
        chk("R5 no flag", 32'(unavail), 0);
    endtask

    task automatic t_base_locked();
        logic [31:0] v;
        wr(2'd1, 32'h0000_2000);
        step(2);
        rd(2'd1, v); chk("R2 write ignored", v, 32'h0000_1000);
    endtask

    task automatic t_poll_active();
        logic [31:0] v;
        wr(2'd0, 32'h0000_0005);
        step(3);
        chk("R10 active kept", 32'(rx_state), 32'(S_ACT));
        chk("R10 no fetch", 32'(mem_req), 0);
        rd(2'd0, v); chk("R7 poll readback", v, 32'h0000_0005);
    endtask

    task automatic t_advance_host();
        logic [31:0] v;
        own[1] = 1'b0;
        pulse(desc_done);
        chk("R11 fetch", 32'(rx_state), 32'(S_FETCH));
        chk("R11 ptr", cur_ptr, 32'h0000_1010);
        step(2);
        chk("R5 suspended", 32'(rx_state), 32'(S_SUSP));
        chk("R6 flag set", 32'(unavail), 1);
        rd(2'd2, v); chk("R5 stat bit7", v, 32'h0000_0080);
    endtask

    task automatic t_clear();
        wr(2'd2, 32'h0000_007F);
        chk("R13 zero keeps", 32'(unavail), 1);
        wr(2'd2, 32'h0000_0080);
        chk("R13 w1c", 32'(unavail), 0);
    endtask

    task automatic t_poll_host();
        wr(2'd0, 32'hDEAD_BEEF);
        chk("R7 not yet", 32'(rx_state), 32'(S_SUSP));
        step(1);
        chk("R7 refetch", 32'(rx_state), 32'(S_FETCH));
        chk("R7 same ptr", mem_addr, 32'h0000_1010);
        step(2);
        chk("R8 back susp", 32'(rx_state), 32'(S_SUSP));
        chk("R8 no flag", 32'(unavail), 0);
    endtask

    task automatic t_poll_owned();
        own[1] = 1'b1;
        wr(2'd0, 32'h0);
        step(3);
        chk("R9 active", 32'(rx_state), 32'(S_ACT));
        chk("R9 ptr", cur_ptr, 32'h0000_1010);
    endtask

    task automatic t_stop_active();
        pulse(stop_cmd);
        chk("R12 stop active", 32'(rx_state), 32'(S_STOP));
        wr(2'd0, 32'h1);
        step(3);
        chk("R10 stopped kept", 32'(rx_state), 32'(S_STOP));
        chk("R10 no req", 32'(mem_req), 0);
    endtask

    task automatic t_stop_fetch();
        hold_ack = 1'b1;
        pulse(start_cmd);
        pulse(stop_cmd);
        step(1);
        chk("R12 waits ack", 32'(rx_state), 32'(S_FETCH));
        hold_ack = 1'b0;
        step(2);
        chk("R12 stop after ack", 32'(rx_state), 32'(S_STOP));
    endtask

    task automatic t_stop_susp();
        own[0] = 1'b0;
        pulse(start_cmd);
        step(2);
        chk("R5 start host", 32'(rx_state), 32'(S_SUSP));
        pulse(stop_cmd);
        chk("R12 stop susp", 32'(rx_state), 32'(S_STOP));
    endtask

    initial begin
        for (int i = 0; i < 8; i++) own[i] = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_base_align();
        t_start_owned();
        t_base_locked();
        t_poll_active();
        t_advance_host();
        t_clear();
        t_poll_host();
        t_poll_owned();
        t_stop_active();
        t_stop_fetch();
        t_stop_susp();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule